// File: doc/BRIEF.md
# Byte-Code SPI Sequencer

This block is a half-duplex SPI master whose transfers are driven by a tiny program rather than by length and control registers. Software loads up to eight one-byte instructions into a 64-bit program register. The engine then runs them one after another, starting with the most significant byte. The instructions pick a chip select and shift bytes out of a 64-bit transmit holding register. Others shift bytes into a 64-bit receive holding register, copy transmit data across, loop back under a counter, or stop.

The transmit and receive holding registers each carry a full flag, and these flags pace the program. A shift-out waits until software has supplied transmit data. A shift-in waits until software has drained the previous receive word. A status word reports the engine state, both full flags and the sticky misuse flags. Software can clear those flags by writing two reset patterns in a row to the clock configuration register, which also holds the SCK divider. Software reaches everything through a plain 64-bit read/write port with a 4-bit word address.

Top module: `seqspi_engine`

## Requirements
- R1: After reset the status word (address 8) reads 64'h0001_0000_0000_0000: state field bits 55:48 equal 8'h01 (idle) and every flag is clear. All cs_n lines are high and sck is low.
- R2: Writing the program register (address 7) while idle starts execution at slot 0, which is bits 63:56, and continues toward bits 7:0. Opcode 8'h00 (or any undefined code) halts the engine at once. Running past slot 7 also halts it.
- R3: Opcode 8'h1n with 1 <= n <= NUM_CS drives cs_n[n-1] low and all other cs_n lines high. n = 0 raises every line. At most one line is low at any time.
- R4: Opcode 8'h3n shifts n bytes out of the transmit register (address 5), MSB first, taking byte k from bits 63-8k : 56-8k. A transmit write sets TX-full (status bit 59). Completing the instruction clears it. The opcode stalls while TX-full is clear.
- R5: Opcode 8'h4n shifts n bytes in. The received bytes land right-aligned in the receive register (address 6), with the first byte most significant. Completion sets RX-full (status bit 63). A read of address 6 clears it. The opcode stalls while RX-full is set.
- R6: Opcode 8'hEn jumps to slot n when the loop field is nonzero and decrements that field. Otherwise it falls through. The loop field is bits 39:32 of address 1. A loop value of L runs the loop body L+1 times, and the field reads 0 afterward.
- R7: SPI mode 0: sck idles low. Data changes on falling edges and is sampled on rising edges. sck toggles every D+1 clocks, where D is bits 63:52 of the clock configuration register (address 3).
- R8: A transmit write while TX-full is set is dropped, and it sets the TX-overrun flag (bit 58). A receive read while RX-full is clear sets the RX-underrun flag (bit 61). Both flags stay set.
- R9: Two consecutive writes to address 3 perform a soft reset. The first has bits 39:36 = 4'b0101 and the second has 4'b1010. The soft reset clears all flags, returns the engine to idle and raises all cs_n lines. The second pattern alone has no effect.
- R10: Opcode 8'hC0 copies the transmit register into the receive register and sets RX-full. It stalls while RX-full is set.
- R11: While a program is stalled waiting for transmit data, the state field reads 8'h02, not idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 6 has a side effect) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench models an SPI target that captures every byte with the chip-select pattern present at that moment, and it answers with a scripted byte stream. One check counts the bytes a loop sends across repeated stalls. A design that runs the body L times, or that fails to decrement the loop field, sends two bytes instead of three or never halts. Another check reads the receive word after a short shift-in. If the bytes were packed at the top, or in reverse order, that word would not match the right-aligned value 16'hC37E. Further checks cover the divider, where an off-by-one half-period reads 30 or 50 ns instead of 40. They also cover the reset pair: firing the soft reset on the second pattern alone would clear the overrun flag too early.

// File: rtl/seqspi_pkg.sv
package seqspi_pkg;

    localparam int WORD_W = 64;
    localparam int ADDR_W = 4;
    localparam int DIV_W  = 12;
    localparam int ARG_W  = 4;

    localparam logic [ADDR_W-1:0] A_LOOP   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CLKCFG = 4'd3;
    localparam logic [ADDR_W-1:0] A_TXD    = 4'd5;
    localparam logic [ADDR_W-1:0] A_RXD    = 4'd6;
    localparam logic [ADDR_W-1:0] A_PROG   = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd8;

    localparam logic [3:0] RST_PAT_A = 4'b0101;
    localparam logic [3:0] RST_PAT_B = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_OUT_GO, ST_OUT_WAIT, ST_IN_GO, ST_IN_WAIT
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_HALT, OP_SEL, OP_OUT, OP_IN, OP_COPY, OP_JUMP
    } op_kind_e;

    typedef struct packed {
        op_kind_e         kind;
        logic [ARG_W-1:0] arg;
    } op_t;

    function automatic logic [7:0] state_code(seq_state_e s);
        case (s)
            ST_IDLE:                 return 8'h01;
            ST_FETCH:                return 8'h02;
            ST_OUT_GO, ST_OUT_WAIT:  return 8'h04;
            default:                 return 8'h08;
        endcase
    endfunction

    function automatic logic [7:0] byte_at(logic [WORD_W-1:0] w, logic [2:0] k);
        return w[8*(7-int'(k)) +: 8];
    endfunction

endpackage

// File: rtl/seqspi_op_decode.sv
module seqspi_op_decode
    import seqspi_pkg::*;
(
    input  logic [7:0] code,
    output op_t        op
);
    always_comb begin
        op.arg  = code[3:0];
        op.kind = OP_HALT;
        case (code[7:4])
            4'h1: op.kind = OP_SEL;
            4'h3: op.kind = OP_OUT;
            4'h4: op.kind = OP_IN;
            4'hC: op.kind = (code[3:0] == 4'h0) ? OP_COPY : OP_HALT;
            4'hE: op.kind = OP_JUMP;
            default: op.kind = OP_HALT;
        endcase
    end
endmodule

// File: rtl/seqspi_byte_shifter.sv
module seqspi_byte_shifter
    import seqspi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte,
    output logic             sck,
    output logic             mosi
);
    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       tx_sr;
        logic [7:0]       rx_sr;
        logic             done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (abort) begin
            sh_d.busy = 1'b0;
            sh_d.sck  = 1'b0;
            sh_d.cnt  = '0;
        end else if (!sh_q.busy) begin
            if (start) begin
                sh_d.busy  = 1'b1;
                sh_d.sck   = 1'b0;
                sh_d.cnt   = '0;
                sh_d.bitn  = '0;
                sh_d.tx_sr = tx_byte;
            end
        end else if (sh_q.cnt >= div) begin
            sh_d.cnt = '0;
            sh_d.sck = !sh_q.sck;
            if (!sh_q.sck) begin
                sh_d.rx_sr = {sh_q.rx_sr[6:0], miso};
            end else if (sh_q.bitn == 3'd7) begin
                sh_d.busy = 1'b0;
                sh_d.done = 1'b1;
            end else begin
                sh_d.bitn  = sh_q.bitn + 3'd1;
                sh_d.tx_sr = {sh_q.tx_sr[6:0], 1'b0};
            end
        end else begin
            sh_d.cnt = sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy    = sh_q.busy;
    assign done    = sh_q.done;
    assign rx_byte = sh_q.rx_sr;
    assign sck     = sh_q.sck;
    assign mosi    = sh_q.busy & sh_q.tx_sr[7];

    AST_SCK_LOW_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.busy |-> !sck);  // R7

    AST_SCK_HOLDS_MID_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.busy && !abort && sh_q.cnt < div) |=> $stable(sck));  // R7
endmodule

// File: rtl/seqspi_engine.sv
module seqspi_engine
    import seqspi_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int PC_W = 4;

    typedef struct packed {
        seq_state_e        st;
        logic [PC_W-1:0]   pc;
        logic [ARG_W-1:0]  nbytes;
        logic [ARG_W-1:0]  idx;
        logic [ARG_W-1:0]  cs_sel;
        logic [7:0]        loops;
        logic [WORD_W-1:0] clk_cfg;
        logic [WORD_W-1:0] tx_data;
        logic              tx_full;
        logic [WORD_W-1:0] rx_data;
        logic              rx_full;
        logic [WORD_W-1:0] rx_acc;
        logic [WORD_W-1:0] prog;
        logic              tx_ovr;
        logic              rx_unr;
        logic              armed;
    } eng_t;

    eng_t eng_d, eng_q;

    op_t         cur_op;
    logic        sh_start, sh_abort, sh_busy, sh_done;
    logic [7:0]  sh_tx, sh_rx;
    logic [WORD_W-1:0] acc_next;

    seqspi_op_decode u_dec (
        .code (byte_at(eng_q.prog, eng_q.pc[2:0])),
        .op   (cur_op)
    );

    seqspi_byte_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (sh_abort),
        .div     (eng_q.clk_cfg[WORD_W-1 -: DIV_W]),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sck     (sck),
        .mosi    (mosi)
    );

    assign acc_next = {eng_q.rx_acc[WORD_W-9:0], sh_rx};

    always_comb begin
        eng_d    = eng_q;
        sh_start = 1'b0;
        sh_abort = 1'b0;
        sh_tx    = 8'h00;

        case (eng_q.st)
            ST_FETCH: begin
                if (eng_q.pc[PC_W-1]) begin
                    eng_d.st = ST_IDLE;
                end else begin
                    case (cur_op.kind)
                        OP_SEL: begin
                            eng_d.cs_sel = cur_op.arg;
                            eng_d.pc     = eng_q.pc + 4'd1;
                        end
                        OP_OUT: begin
                            if (cur_op.arg == '0) begin
                                eng_d.pc = eng_q.pc + 4'd1;
                            end else if (eng_q.tx_full) begin
                                eng_d.st     = ST_OUT_GO;
                                eng_d.nbytes = cur_op.arg;
                                eng_d.idx    = '0;
                            end
                        end
                        OP_IN: begin
                            if (cur_op.arg == '0) begin
                                eng_d.pc = eng_q.pc + 4'd1;
                            end else if (!eng_q.rx_full) begin
                                eng_d.st     = ST_IN_GO;
                                eng_d.nbytes = cur_op.arg;
                                eng_d.idx    = '0;
                                eng_d.rx_acc = '0;
                            end
                        end
                        OP_COPY: begin
                            if (!eng_q.rx_full) begin
                                eng_d.rx_data = eng_q.tx_data;
                                eng_d.rx_full = 1'b1;
                                eng_d.pc      = eng_q.pc + 4'd1;
                            end
                        end
                        OP_JUMP: begin
                            if (eng_q.loops != 8'd0) begin
                                eng_d.loops = eng_q.loops - 8'd1;
                                eng_d.pc    = cur_op.arg;
                            end else begin
                                eng_d.pc = eng_q.pc + 4'd1;
                            end
                        end
                        default: eng_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_OUT_GO: begin
                sh_start = 1'b1;
                sh_tx    = byte_at(eng_q.tx_data, eng_q.idx[2:0]);
                eng_d.st = ST_OUT_WAIT;
            end
            ST_OUT_WAIT: begin
                if (sh_done) begin
                    if (eng_q.idx + 4'd1 == eng_q.nbytes) begin
                        eng_d.tx_full = 1'b0;
                        eng_d.pc      = eng_q.pc + 4'd1;
                        eng_d.st      = ST_FETCH;
                    end else begin
                        eng_d.idx = eng_q.idx + 4'd1;
                        eng_d.st  = ST_OUT_GO;
                    end
                end
            end
            ST_IN_GO: begin
                sh_start = 1'b1;
                eng_d.st = ST_IN_WAIT;
            end
            ST_IN_WAIT: begin
                if (sh_done) begin
                    eng_d.rx_acc = acc_next;
                    if (eng_q.idx + 4'd1 == eng_q.nbytes) begin
                        eng_d.rx_data = acc_next;
                        eng_d.rx_full = 1'b1;
                        eng_d.pc      = eng_q.pc + 4'd1;
                        eng_d.st      = ST_FETCH;
                    end else begin
                        eng_d.idx = eng_q.idx + 4'd1;
                        eng_d.st  = ST_IN_GO;
                    end
                end
            end
            default: ;
        endcase

        if (reg_wr) begin
            case (reg_addr)
                A_LOOP: eng_d.loops = reg_wdata[39:32];
                A_CLKCFG: begin
                    eng_d.clk_cfg = reg_wdata;
                    eng_d.armed   = (reg_wdata[39:36] == RST_PAT_A);
                    if (eng_q.armed && reg_wdata[39:36] == RST_PAT_B) begin
                        sh_abort      = 1'b1;
                        eng_d.st      = ST_IDLE;
                        eng_d.pc      = '0;
                        eng_d.cs_sel  = '0;
                        eng_d.tx_full = 1'b0;
                        eng_d.rx_full = 1'b0;
                        eng_d.tx_ovr  = 1'b0;
                        eng_d.rx_unr  = 1'b0;
                    end
                end
                A_TXD: begin
                    if (eng_q.tx_full) begin
                        eng_d.tx_ovr = 1'b1;
                    end else begin
                        eng_d.tx_data = reg_wdata;
                        eng_d.tx_full = 1'b1;
                    end
                end
                A_PROG: begin
                    if (eng_q.st == ST_IDLE) begin
                        eng_d.prog = reg_wdata;
                        eng_d.pc   = '0;
                        eng_d.st   = ST_FETCH;
                    end
                end
                default: ;
            endcase
        end

        if (reg_rd && reg_addr == A_RXD) begin
            if (eng_q.rx_full) eng_d.rx_full = 1'b0;
            else               eng_d.rx_unr  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_LOOP:   reg_rdata = {24'd0, eng_q.loops, 32'd0};
            A_CLKCFG: reg_rdata = eng_q.clk_cfg;
            A_TXD:    reg_rdata = eng_q.tx_data;
            A_RXD:    reg_rdata = eng_q.rx_data;
            A_PROG:   reg_rdata = eng_q.prog;
            A_STAT:   reg_rdata = {eng_q.rx_full, 1'b0, eng_q.rx_unr, 1'b0,
                                   eng_q.tx_full, eng_q.tx_ovr, 2'b00,
                                   state_code(eng_q.st), 48'd0};
            default:  reg_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = (eng_q.cs_sel != ARG_W'(g + 1));
    end

    AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));  // R3

    AST_TX_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TXD && !eng_q.tx_full) |=> eng_q.tx_full);  // R4

    AST_START_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_OUT_GO || eng_q.st == ST_IN_GO) |-> !sh_busy);  // R4

    AST_RX_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_RXD && eng_q.rx_full) |=> !eng_q.rx_full);  // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.tx_ovr && !(reg_wr && reg_addr == A_CLKCFG)) |=> eng_q.tx_ovr);  // R8

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_IDLE) |-> !sh_start);  // R2
endmodule

// File: tb/seqspi_engine_tb_top.sv
module seqspi_engine_tb_top;
    localparam int NCS = 4;
    localparam logic [63:0] IDLE_STAT = 64'h0001_0000_0000_0000;
    localparam logic [63:0] PAT_A = 64'h0000_0050_0000_0000;
    localparam logic [63:0] PAT_B = 64'h0000_00A0_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [63:0] reg_wdata = 64'd0, reg_rdata;
    logic sck, mosi, miso;
    logic [NCS-1:0] cs_n;

    int n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    seqspi_engine #(.NUM_CS(NCS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // SPI target model, mode 0
    logic [7:0] resp [0:15];
    logic [7:0] capt [0:63];
    logic [NCS-1:0] capcs [0:63];
    int ncap = 0, ridx = 0, sbit = 0;
    bit load_pend = 0;
    logic [7:0] s_in = 8'h00, s_out = 8'h00;
    assign miso = s_out[7];

    always @(posedge sck) begin
        s_in = {s_in[6:0], mosi};
        sbit++;
        if (sbit == 8) begin
            if (ncap < 64) begin
                capt[ncap]  = s_in;
                capcs[ncap] = cs_n;
            end
            ncap++;
            sbit = 0;
            load_pend = 1;
        end
    end

    always @(negedge sck) begin
        if (load_pend) begin
            s_out = resp[ridx % 16];
            ridx++;
            load_pend = 0;
        end else begin
            s_out = {s_out[6:0], 1'b0};
        end
    end

    task automatic prime();
        ncap = 0; sbit = 0; load_pend = 0;
        s_out = resp[0]; ridx = 1;
    endtask

    task automatic set_resp_zero();
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] s;
        bit ok = 0;
        for (int i = 0; i < 4000; i++) begin
            rd(4'd8, s);
            if (s[55:48] == 8'h01) begin ok = 1; break; end
        end
        chk(req, 64'(ok), 64'd1);
    endtask

    task automatic wait_tx_empty(input string req);
        logic [63:0] s;
        bit ok = 0;
        for (int i = 0; i < 4000; i++) begin
            rd(4'd8, s);
            if (!s[59]) begin ok = 1; break; end
        end
        chk(req, 64'(ok), 64'd1);
    endtask

    task automatic soft_reset(input logic [11:0] div);
        wr(4'd3, PAT_A);
        wr(4'd3, PAT_B);
        wr(4'd3, {div, 52'd0});
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(4'd8, v);
        chk("R1 status", v, IDLE_STAT);
        chk("R1 cs_n", 64'(cs_n), 64'hF);
        chk("R1 sck", 64'(sck), 64'd0);
    endtask

    task automatic t_shift_out();
        logic [63:0] v;
        set_resp_zero(); prime();
        wr(4'd3, {12'd1, 52'd0});
        wr(4'd5, 64'h1122_3344_5566_7788);
        rd(4'd8, v);
        chk("R4 txfull set", 64'(v[59]), 64'd1);
        wr(4'd7, 64'h1133_1000_0000_0000);
        wait_idle("R2 out halts");
        chk("R4 byte count", 64'(ncap), 64'd3);
        chk("R4 byte0", 64'(capt[0]), 64'h11);
        chk("R4 byte1", 64'(capt[1]), 64'h22);
        chk("R4 byte2", 64'(capt[2]), 64'h33);
        chk("R3 cs0 low", 64'(capcs[0]), 64'hE);
        rd(4'd8, v);
        chk("R4 txfull clear", 64'(v[59]), 64'd0);
        chk("R3 deselect", 64'(cs_n), 64'hF);
    endtask

    task automatic t_shift_in();
        logic [63:0] v;
        set_resp_zero();
        resp[0] = 8'h5A; resp[1] = 8'hC3; resp[2] = 8'h7E;
        prime();
        wr(4'd5, 64'hA500_0000_0000_0000);
        wr(4'd7, 64'h1231_4210_0000_0000);
        wait_idle("R5 in halts");
        chk("R4 out byte", 64'(capt[0]), 64'hA5);
        chk("R3 cs1 low", 64'(capcs[0]), 64'hD);
        rd(4'd8, v);
        chk("R5 rxfull set", 64'(v[63]), 64'd1);
        rd(4'd6, v);
        chk("R5 rx right aligned", v, 64'h0000_0000_0000_C37E);
        rd(4'd8, v);
        chk("R5 rxfull cleared", 64'(v[63]), 64'd0);
        rd(4'd6, v);
        rd(4'd8, v);
        chk("R8 rx underrun", 64'(v[61]), 64'd1);
        soft_reset(12'd1);
        rd(4'd8, v);
        chk("R9 underrun cleared", v, IDLE_STAT);
    endtask

    task automatic t_loop();
        logic [63:0] v;
        set_resp_zero(); prime();
        wr(4'd1, 64'h0000_0002_0000_0000);
        wr(4'd5, 64'hAB00_0000_0000_0000);
        wr(4'd7, 64'h1131_E110_0000_0000);
        wait_tx_empty("R6 first pass");
        repeat (100) @(negedge clk);
        rd(4'd8, v);
        chk("R11 stalled state", 64'(v[55:48]), 64'h02);
        chk("R4 stall no bytes", 64'(ncap), 64'd1);
        wr(4'd5, 64'hCD00_0000_0000_0000);
        wait_tx_empty("R6 second pass");
        wr(4'd5, 64'hEF00_0000_0000_0000);
        wait_idle("R6 loop ends");
        chk("R6 body runs L+1", 64'(ncap), 64'd3);
        chk("R6 pass1", 64'(capt[1]), 64'hCD);
        chk("R6 pass2", 64'(capt[2]), 64'hEF);
        rd(4'd1, v);
        chk("R6 count drained", 64'(v[39:32]), 64'd0);
    endtask

    task automatic t_divider();
        time t0, t1, t2;
        set_resp_zero(); prime();
        wr(4'd3, {12'd3, 52'd0});
        wr(4'd5, 64'h9600_0000_0000_0000);
        wr(4'd7, 64'h1131_1000_0000_0000);
        @(posedge sck); t0 = $time;
        @(negedge sck); t1 = $time;
        @(posedge sck); t2 = $time;
        chk("R7 high half", 64'(t1 - t0), 64'd40);
        chk("R7 low half", 64'(t2 - t1), 64'd40);
        wait_idle("R7 done");
        chk("R7 mode0 byte", 64'(capt[0]), 64'h96);
        wr(4'd3, {12'd1, 52'd0});
    endtask

    task automatic t_overrun_reset();
        logic [63:0] v;
        wr(4'd5, 64'h0102_0304_0506_0708);
        wr(4'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(4'd8, v);
        chk("R8 tx overrun", 64'(v[58]), 64'd1);
        rd(4'd5, v);
        chk("R8 write dropped", v, 64'h0102_0304_0506_0708);
        wr(4'd3, PAT_B);
        rd(4'd8, v);
        chk("R9 lone pattern ignored", 64'(v[59:58]), 64'h3);
        soft_reset(12'd1);
        rd(4'd8, v);
        chk("R9 flags cleared", v, IDLE_STAT);
    endtask

    task automatic t_copy();
        logic [63:0] v;
        wr(4'd5, 64'h0123_4567_89AB_CDEF);
        wr(4'd7, 64'hC000_0000_0000_0000);
        wait_idle("R10 copy halts");
        rd(4'd8, v);
        chk("R10 rxfull", 64'(v[63]), 64'd1);
        rd(4'd6, v);
        chk("R10 copied", v, 64'h0123_4567_89AB_CDEF);
        soft_reset(12'd1);
    endtask

    task automatic t_halt();
        logic [63:0] v;
        set_resp_zero(); prime();
        wr(4'd5, 64'h7700_0000_0000_0000);
        wr(4'd7, 64'h0011_3100_0000_0000);
        wait_idle("R2 halt");
        repeat (50) @(negedge clk);
        chk("R2 no bytes after halt", 64'(ncap), 64'd0);
        chk("R2 cs untouched", 64'(cs_n), 64'hF);
        rd(4'd8, v);
        chk("R2 tx still full", 64'(v[59]), 64'd1);
        soft_reset(12'd1);
    endtask

    initial begin
        set_resp_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shift_out();
        t_shift_in();
        t_loop();
        t_divider();
        t_overrun_reset();
        t_copy();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule